// File: doc/BRIEF.md
# Self-Synchronizing Bit-Serial Cipher

This block encrypts or decrypts a serial bit stream, one bit per accepted input cycle. Its key bit in every cycle comes from a nonlinear function of the most recent ciphertext bits, combined with a loaded initial vector. The ciphertext is fed back into the state, so a decryptor that starts from the same initial vector follows the encryptor without any framing. After a corrupted ciphertext bit, it falls back into step on its own once the bad bit has left its history.

One mode input selects the direction. In encrypt mode the input is plaintext, and the output ciphertext is shifted into the history. In decrypt mode the input is ciphertext, and that input is shifted into the history. Loading an initial vector clears the history, which starts a new session. Each output bit is registered and is flagged valid for one cycle.

Top module: `ssc_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid and out_bit are 0. Reset clears the ciphertext history and the stored vector to zero.
- R2: An input accepted on edge k produces out_valid high for exactly the following cycle. An input is accepted when in_valid is 1 and iv_load is 0. With no accepted input, out_valid is 0 after the edge.
- R3: The output bit is in_bit XOR key. The key is computed as follows. Let v = history XOR stored vector, with HIST_W bits. The key is the XOR of all bits of v, XORed with the XOR over i < HIST_W/2 of (v[i] AND v[i+HIST_W/2]).
- R4: On each accepted input, the history shifts left by one and the ciphertext bit enters at bit 0. In encrypt mode (decrypt=0) the ciphertext bit is the output bit. In decrypt mode (decrypt=1) it is in_bit.
- R5: A decryptor loaded with the same vector and fed the ciphertext stream outputs the original plaintext.
- R6: iv_load=1 stores iv_value and clears the history to zero. An in_valid in the same cycle is ignored: it gives no output and no shift.
- R7: While in_valid is 0, the history and the stored vector hold their values. Idle gaps therefore do not change the key sequence.
- R8: After one flipped ciphertext bit at index e, the decryptor output at index e is the inverted plaintext bit. Every output from index e+HIST_W+1 onward equals the plaintext again.
- R9: out_bit keeps its previous value on any cycle that accepts no input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| iv_load | input | 1 | Load iv_value and clear the history |
| iv_value | input | HIST_W | Initial vector |
| decrypt | input | 1 | 0 = encrypt, 1 = decrypt |
| in_bit | input | 1 | Data input bit |
| in_valid | input | 1 | in_bit is valid this cycle |
| out_bit | output | 1 | Registered result bit |
| out_valid | output | 1 | out_bit carries a new result |

## Verification
The bench runs the decrypt direction with one flipped ciphertext bit and checks three things. The output at the error index must be inverted. The outputs must match the plaintext from HIST_W+1 bits later. A design that shifted the output instead of the input in decrypt mode would stay wrong for good. Random idle gaps test that state and out_bit hold while in_valid is low, which a free-running register would fail. An iv_load issued together with in_valid tests that the load wins, and that the history clear makes a repeated session give the same ciphertext.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic {
    DIR_ENC = 1'b0,
    DIR_DEC = 1'b1
  } dir_e;
endpackage

// File: rtl/ssc_keygen.sv
module ssc_keygen #(
  parameter int W = 16
) (
  input  logic [W-1:0] hist,
  input  logic [W-1:0] iv,
  output logic         key
);
  localparam int HALF = W / 2;

  logic [W-1:0]    mix;
  logic [HALF-1:0] prod;

  assign mix = hist ^ iv;

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    assign prod[i] = mix[i] & mix[i+HALF];
  end

  assign key = (^mix) ^ (^prod);
endmodule

// File: rtl/ssc_history.sv
module ssc_history #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] iv_in,
  input  logic         shift_en,
  input  logic         shift_bit,
  output logic [W-1:0] hist_q,
  output logic [W-1:0] iv_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      iv_q   <= '0;
    end else if (load) begin
      hist_q <= '0;
      iv_q   <= iv_in;
    end else if (shift_en) begin
      hist_q <= {hist_q[W-2:0], shift_bit};
    end
  end
endmodule

// File: rtl/ssc_outreg.sv
module ssc_outreg (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic bit_in,
  output logic bit_q,
  output logic valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire;
      if (fire) bit_q <= bit_in;
    end
  end
endmodule

// File: rtl/ssc_unit.sv
module ssc_unit #(
  parameter int HIST_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iv_load,
  input  logic [HIST_W-1:0] iv_value,
  input  logic              decrypt,
  input  logic              in_bit,
  input  logic              in_valid,
  output logic              out_bit,
  output logic              out_valid
);
  import ssc_pkg::*;

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] iv_q;
  logic              key_bit;
  logic              result;
  logic              accept;
  logic              cipher_bit;
  dir_e              dir;

  assign dir        = dir_e'(decrypt);
  assign accept     = in_valid & ~iv_load;
  assign result     = in_bit ^ key_bit;
  assign cipher_bit = (dir == DIR_DEC) ? in_bit : result;

  ssc_keygen #(.W(HIST_W)) keygen_i (
    .hist (hist_q),
    .iv   (iv_q),
    .key  (key_bit)
  );

  ssc_history #(.W(HIST_W)) history_i (
    .clk       (clk),
    .rst       (rst),
    .load      (iv_load),
    .iv_in     (iv_value),
    .shift_en  (accept),
    .shift_bit (cipher_bit),
    .hist_q    (hist_q),
    .iv_q      (iv_q)
  );

  ssc_outreg outreg_i (
    .clk     (clk),
    .rst     (rst),
    .fire    (accept),
    .bit_in  (result),
    .bit_q   (out_bit),
    .valid_q (out_valid)
  );
endmodule

// File: rtl/ssc_unit_chk.sv
module ssc_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         iv_load,
  input logic [W-1:0] iv_value,
  input logic         decrypt,
  input logic         in_bit,
  input logic         in_valid,
  input logic         out_bit,
  input logic         out_valid,
  input logic         key_bit,
  input logic [W-1:0] hist_q,
  input logic [W-1:0] iv_q
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_bit && hist_q == '0 && iv_q == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !iv_load) |=> out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && !iv_load) |=> !out_valid);

  a_r3_xor_key: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !iv_load) |=> (out_bit == ($past(in_bit) ^ $past(key_bit))));

  a_r4_shift_cipher: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !iv_load) |=>
      (hist_q[W-1:1] == $past(hist_q[W-2:0]) &&
       hist_q[0] == ($past(decrypt) ? $past(in_bit) : out_bit)));

  a_r6_load_clears: assert property (@(posedge clk) disable iff (rst)
    iv_load |=> (hist_q == '0 && iv_q == $past(iv_value)));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !iv_load) |=> ($stable(hist_q) && $stable(iv_q)));

  a_r9_bit_hold: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && !iv_load) |=> $stable(out_bit));
endmodule

bind ssc_unit ssc_unit_chk #(.W(HIST_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .iv_load   (iv_load),
  .iv_value  (iv_value),
  .decrypt   (decrypt),
  .in_bit    (in_bit),
  .in_valid  (in_valid),
  .out_bit   (out_bit),
  .out_valid (out_valid),
  .key_bit   (key_bit),
  .hist_q    (hist_q),
  .iv_q      (iv_q)
);

// File: tb/ssc_unit_tb.sv
module ssc_unit_tb_top;
  localparam int HW      = 16;
  localparam int CLK_PER = 10;
  localparam int NSTR    = 60;
  localparam int ERR_IX  = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          iv_load = 1'b0;
  logic [HW-1:0] iv_value = '0;
  logic          decrypt = 1'b0;
  logic          in_bit = 1'b0;
  logic          in_valid = 1'b0;
  logic          out_bit;
  logic          out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [HW-1:0] m_hist;
  logic [HW-1:0] m_iv;
  logic          m_out;
  logic          last_exp;
  logic [NSTR-1:0] pt;
  logic [NSTR-1:0] ct;

  always #(CLK_PER/2) clk = ~clk;

  ssc_unit #(.HIST_W(HW)) dut_i (
    .clk(clk), .rst(rst), .iv_load(iv_load), .iv_value(iv_value),
    .decrypt(decrypt), .in_bit(in_bit), .in_valid(in_valid),
    .out_bit(out_bit), .out_valid(out_valid)
  );

  function automatic logic ref_key(input logic [HW-1:0] h, input logic [HW-1:0] iv);
    logic [HW-1:0] v;
    logic k;
    v = h ^ iv;
    k = ^v;
    for (int i = 0; i < HW/2; i++) k = k ^ (v[i] & v[i+HW/2]);
    return k;
  endfunction

  task automatic check(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", rq, act, exp, $time);
    end
  endtask

  // Called at a negedge; returns at the next negedge after checking.
  task automatic send(input logic v, input logic b);
    logic exp_b;
    exp_b = m_out;
    in_valid = v;
    in_bit   = b;
    if (v) begin
      exp_b  = b ^ ref_key(m_hist, m_iv);
      m_hist = {m_hist[HW-2:0], decrypt ? b : exp_b};
      m_out  = exp_b;
    end
    @(negedge clk);
    in_valid = 1'b0;
    last_exp = exp_b;
    check(v ? "R2 valid" : "R2 idle valid", out_valid, v);
    if (v) check("R3 cipher bit", out_bit, exp_b);
    else   check("R9 bit hold", out_bit, exp_b);
  endtask

  task automatic load(input logic [HW-1:0] x);
    iv_load  = 1'b1;
    iv_value = x;
    in_valid = 1'b1;
    in_bit   = 1'b1;
    @(negedge clk);
    iv_load  = 1'b0;
    in_valid = 1'b0;
    m_iv     = x;
    m_hist   = '0;
    check("R6 load ignores input", out_valid, 1'b0);
    check("R6 out bit held", out_bit, m_out);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [HW-1:0] iv_a;
    void'($urandom(32'd4242));
    m_hist = '0; m_iv = '0; m_out = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", out_valid, 1'b0);
    check("R1 bit in reset", out_bit, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", out_valid, 1'b0);
    // zero state: key must be 0, so output equals input (R1, R3)
    send(1'b1, 1'b1);
    check("R1 zero state passes data", out_bit, 1'b1);

    // random encrypt with gaps (R3, R4, R7, R9)
    iv_a = 16'($urandom);
    load(iv_a);
    for (int i = 0; i < 300; i++) begin
      if (($urandom % 4) == 0) send(1'b0, 1'($urandom));
      else send(1'b1, 1'($urandom));
    end

    // session capture for decryption (R6: load clears history)
    load(iv_a);
    for (int i = 0; i < NSTR; i++) begin
      pt[i] = 1'($urandom);
      send(1'b1, pt[i]);
      ct[i] = last_exp;
      if (i % 7 == 3) send(1'b0, 1'b1);
    end

    // clean decrypt (R5)
    decrypt = 1'b1;
    load(iv_a);
    for (int i = 0; i < NSTR; i++) begin
      send(1'b1, ct[i]);
      check("R5 recovered plaintext", out_bit, pt[i]);
      if (i % 5 == 2) send(1'b0, 1'b0);
    end

    // decrypt with one flipped ciphertext bit (R8, R4 decrypt shift)
    load(iv_a);
    for (int i = 0; i < NSTR; i++) begin
      send(1'b1, ct[i] ^ (i == ERR_IX));
      if (i == ERR_IX) check("R8 error bit inverted", out_bit, ~pt[i]);
      else if (i < ERR_IX || i > ERR_IX + HW) check("R8 resync", out_bit, pt[i]);
    end

    // random decrypt stream against the model (R4)
    for (int i = 0; i < 200; i++) send(1'($urandom % 3 != 0), 1'($urandom));
    decrypt = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule